// File: doc/BRIEF.md
# Indexed Interrupt Mask Set/Clear Unit

This block holds one mask bit per interrupt request source; a mask bit of 1 blocks its source. Software changes the mask through two byte-wide command ports, one that masks and one that unmasks. Each command names one source by index or, through a flag bit, acts on every source at once. An interrupt service routine can therefore enable or disable a single source with one write, without a read-modify-write of the full mask.

A full-width write path loads the whole mask in one cycle, and the current mask is always visible on an output for reading. The unit ANDs the raw request vector with the inverted mask and registers the result, which a downstream priority stage uses.

Command byte layout, for both ports: bits 5:0 hold the source index, bit 6 is the all-sources flag, and bit 7 is reserved.

Top module: `imask_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every mask bit becomes 1 and `req_masked` becomes all zeros.
- R2: A set-port write with bit 6 clear sets the mask bit whose index is in bits 5:0. All other mask bits keep their values.
- R3: A set-port write with bit 6 set sets every mask bit, whatever bits 5:0 hold.
- R4: A clear-port write with bit 6 clear clears the mask bit whose index is in bits 5:0. All other mask bits keep their values.
- R5: A clear-port write with bit 6 set clears every mask bit, whatever bits 5:0 hold.
- R6: Bit 7 of either command byte has no effect on the mask.
- R7: When both command ports are written in the same cycle, only the set command is applied. The clear command is dropped entirely.
- R8: A full-width write loads `mask_wdata` into the mask. It overrides both command ports in the same cycle.
- R9: `mask_q` always shows the current mask, and every change appears on it one clock after the write.
- R10: The command-port read data `cmd_rdata` is always zero.
- R11: After each clock edge, `req_masked` equals `req_raw & ~mask_q` as both were sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_wr | input | 1 | Write strobe for the set (mask) command port |
| set_data | input | 8 | Set command byte |
| clr_wr | input | 1 | Write strobe for the clear (unmask) command port |
| clr_data | input | 8 | Clear command byte |
| mask_wr | input | 1 | Full-width mask write strobe |
| mask_wdata | input | NUM_SRC | Full-width mask write data |
| req_raw | input | NUM_SRC | Raw interrupt requests |
| cmd_rdata | output | 8 | Read data of the command ports, always zero |
| mask_q | output | NUM_SRC | Current mask, 1 = source masked |
| req_masked | output | NUM_SRC | Registered requests that are not masked |

## Verification
Three kinds of write can land in the same cycle: a set command, a clear command and a full-width load. The bench drives these together on purpose. It pairs an indexed set with a clear-all, uses the same index on both ports, and adds a full load on top of both. It also drives random streams in which the three strobes overlap often. After every clock edge, a behavioural reference model applies the priority order full load, then set, then clear. The bench compares the resulting mask and the gated requests with the design outputs.

// File: rtl/imask_pkg.sv
// Package: shared command-byte layout for the interrupt mask unit.
// Assumes both command ports use the same byte format.
package imask_pkg;
    localparam int CMD_W   = 8;
    localparam int IDX_W   = 6;
    localparam int MAX_SRC = 1 << IDX_W;

    typedef struct packed {
        logic             rsvd;
        logic             all;
        logic [IDX_W-1:0] idx;
    } imask_cmd_t;
endpackage

// File: rtl/imask_cmd_dec.sv
// Module: turns a command byte plus its strobe into a per-source hit vector.
// Assumes NUM_SRC <= MAX_SRC. Indices at or above NUM_SRC hit nothing.
// The reserved bit is not looked at.
module imask_cmd_dec
    import imask_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               valid,
    input  logic [CMD_W-1:0]   cmd,
    output logic [NUM_SRC-1:0] hit
);
    imask_cmd_t c;

    // Split the raw byte into its fields.
    always_comb c = imask_cmd_t'(cmd);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
            // A source is hit by the all flag or by a matching index.
            always_comb hit[i] = valid && (c.all || (c.idx == IDX_W'(i)));
        end
    endgenerate
endmodule

// File: rtl/imask_reg.sv
// Module: mask register bank, one flop per source.
// Priority on each bit: full load, then set, then clear.
// Assumes set_hit and clr_hit were already arbitrated by the caller.
module imask_reg #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_SRC-1:0] load_data,
    input  logic [NUM_SRC-1:0] set_hit,
    input  logic [NUM_SRC-1:0] clr_hit,
    output logic [NUM_SRC-1:0] mask
);
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            // Update one mask bit. Reset masks the source.
            always_ff @(posedge clk) begin
                if (!rst_n)          mask[i] <= 1'b1;
                else if (load)       mask[i] <= load_data[i];
                else if (set_hit[i]) mask[i] <= 1'b1;
                else if (clr_hit[i]) mask[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/imask_gate.sv
// Module: registered request gate. A request passes when its mask bit is 0.
// Assumes the mask input is the registered mask of the current cycle.
module imask_gate #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] req_out
);
    // Register the unmasked requests. Reset drops them all.
    always_ff @(posedge clk) begin
        if (!rst_n) req_out <= '0;
        else        req_out <= req & ~mask;
    end
endmodule

// File: rtl/imask_unit.sv
// Module: top of the interrupt mask set/clear unit.
// Arbitrates the two command ports (set wins, clear dropped), decodes
// both ports, keeps the mask and gates the requests.
// Assumes single-cycle write strobes and NUM_SRC <= 64.
module imask_unit
    import imask_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_wr,
    input  logic [CMD_W-1:0]   set_data,
    input  logic               clr_wr,
    input  logic [CMD_W-1:0]   clr_data,
    input  logic               mask_wr,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [NUM_SRC-1:0] req_raw,
    output logic [CMD_W-1:0]   cmd_rdata,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] req_masked
);
    logic               clr_ok;
    logic [NUM_SRC-1:0] set_hit;
    logic [NUM_SRC-1:0] clr_hit;

    // A set write in the same cycle cancels the whole clear command.
    always_comb clr_ok = clr_wr && !set_wr;

    // The command ports read back as zero.
    always_comb cmd_rdata = '0;

    imask_cmd_dec #(.NUM_SRC(NUM_SRC)) u_set_dec (
        .valid (set_wr),
        .cmd   (set_data),
        .hit   (set_hit)
    );

    imask_cmd_dec #(.NUM_SRC(NUM_SRC)) u_clr_dec (
        .valid (clr_ok),
        .cmd   (clr_data),
        .hit   (clr_hit)
    );

    imask_reg #(.NUM_SRC(NUM_SRC)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mask_wr),
        .load_data (mask_wdata),
        .set_hit   (set_hit),
        .clr_hit   (clr_hit),
        .mask      (mask_q)
    );

    imask_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_raw),
        .mask    (mask_q),
        .req_out (req_masked)
    );
endmodule

// File: rtl/imask_unit_chk.sv
// Module: assertion checker for imask_unit, attached with bind.
module imask_unit_chk #(
    parameter int NUM_SRC = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               set_wr,
    input logic [7:0]         set_data,
    input logic               clr_wr,
    input logic [7:0]         clr_data,
    input logic               mask_wr,
    input logic [NUM_SRC-1:0] mask_wdata,
    input logic [NUM_SRC-1:0] req_raw,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] req_masked
);
    localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

    logic set_one, clr_one, set_all, clr_all;
    always_comb set_one = set_wr && !set_data[6] && (int'(set_data[5:0]) < NUM_SRC) && !mask_wr;
    always_comb set_all = set_wr && set_data[6] && !mask_wr;
    always_comb clr_one = clr_wr && !clr_data[6] && (int'(clr_data[5:0]) < NUM_SRC) && !set_wr && !mask_wr;
    always_comb clr_all = clr_wr && clr_data[6] && !set_wr && !mask_wr;

    // R1
    reset_mask_chk: assert property (@(posedge clk) $rose(rst_n) |-> (mask_q == '1 && req_masked == '0));

    // R2
    set_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_one |=> ((mask_q | (ONE << $past(set_data[5:0]))) == mask_q)
               && (((mask_q ^ $past(mask_q)) & ~(ONE << $past(set_data[5:0]))) == '0));

    // R3
    set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_all |=> (mask_q == '1));

    // R4
    clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_one |=> ((mask_q & (ONE << $past(clr_data[5:0]))) == '0)
               && (((mask_q ^ $past(mask_q)) & ~(ONE << $past(clr_data[5:0]))) == '0));

    // R5
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (mask_q == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_one && clr_wr) |=> (mask_q == ($past(mask_q) | (ONE << $past(set_data[5:0])))));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(mask_wdata)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr && !mask_wr) |=> $stable(mask_q));

    // R11
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (req_masked == ($past(req_raw) & ~$past(mask_q))));
endmodule

bind imask_unit imask_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_wr     (set_wr),
    .set_data   (set_data),
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .req_raw    (req_raw),
    .mask_q     (mask_q),
    .req_masked (req_masked)
);

// File: tb/sim_imask_unit.sv
// Bench: behavioural reference model compared with the design after every clock.
module sim_imask_unit;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         set_wr = 1'b0, clr_wr = 1'b0, mask_wr = 1'b0;
    logic [7:0]   set_data = '0, clr_data = '0;
    logic [N-1:0] mask_wdata = '0, req_raw = '0;
    logic [7:0]   cmd_rdata;
    logic [N-1:0] mask_q, req_masked;

    int total = 0;
    int bad = 0;
    logic [N-1:0] m_mask, m_req;

    always #5 clk = ~clk;

    imask_unit #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .set_wr(set_wr), .set_data(set_data),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .req_raw(req_raw), .cmd_rdata(cmd_rdata),
        .mask_q(mask_q), .req_masked(req_masked)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // One clock: apply the model at the edge, compare at the next falling edge.
    task automatic step(input string tag,
                        input logic sw, input logic [7:0] sd,
                        input logic cw, input logic [7:0] cd,
                        input logic mw, input logic [N-1:0] md,
                        input logic [N-1:0] rq);
        logic [N-1:0] old;
        set_wr = sw; set_data = sd; clr_wr = cw; clr_data = cd;
        mask_wr = mw; mask_wdata = md; req_raw = rq;
        @(posedge clk);
        old   = m_mask;
        m_req = rq & ~old;
        if (mw)            m_mask = md;
        else if (sw) begin
            if (sd[6])     m_mask = '1;
            else           m_mask[sd[5:0]] = 1'b1;
        end else if (cw) begin
            if (cd[6])     m_mask = '0;
            else           m_mask[cd[5:0]] = 1'b0;
        end
        @(negedge clk);
        chk({tag, " mask"}, mask_q, m_mask);
        chk({tag, " req"}, req_masked, m_req);
        chk("R10 rdata", {{(N-8){1'b0}}, cmd_rdata}, '0);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        report();
    end

    initial begin
        logic [N-1:0] ones;
        ones = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mask", mask_q, '1);
        chk("R1 req", req_masked, '0);
        m_mask = '1; m_req = '0;
        rst_n = 1'b1;
        // R11: all sources masked, so every request is blocked
        step("R11 blocked", 0, 8'h00, 0, 8'h00, 0, '0, ones);
        // R5: clear-all with a nonzero index field
        step("R5 clear all", 0, 8'h00, 1, 8'h6A, 0, '0, ones);
        // R2: set single bits
        step("R2 set 5", 1, 8'h05, 0, 8'h00, 0, '0, ones);
        step("R2 set 63", 1, 8'h3F, 0, 8'h00, 0, '0, 64'h8000_0000_0000_0021);
        step("R2 set 0", 1, 8'h00, 0, 8'h00, 0, '0, ones);
        // R4: clear a single bit, others kept
        step("R4 clear 5", 0, 8'h00, 1, 8'h05, 0, '0, ones);
        step("R4 clear 63", 0, 8'h00, 1, 8'h3F, 0, '0, 64'hF0F0_0000_1234_5678);
        // R3: set-all ignores the index
        step("R3 set all", 1, 8'h47, 0, 8'h00, 0, '0, ones);
        step("R5 clear all", 0, 8'h00, 1, 8'h63, 0, '0, ones);
        // R6: the reserved bit has no effect
        step("R6 set rsvd", 1, 8'h83, 0, 8'h00, 0, '0, ones);
        step("R6 clr rsvd", 0, 8'h00, 1, 8'h83, 0, '0, ones);
        step("R6 clr all rsvd", 0, 8'h00, 1, 8'hC0, 0, '0, ones);
        // R7: set and clear together, set wins and the clear is dropped
        step("R7 set10 clrall", 1, 8'h0A, 1, 8'h40, 0, '0, ones);
        step("R7 same idx", 1, 8'h0A, 1, 8'h0A, 0, '0, ones);
        step("R7 set2 clr10", 1, 8'h02, 1, 8'h0A, 0, '0, ones);
        step("R7 setall clrall", 1, 8'h40, 1, 8'h40, 0, '0, ones);
        // R8: a full load overrides both command ports
        step("R8 load", 1, 8'h40, 1, 8'h40, 1, 64'hA5A5_0000_FFFF_1234, ones);
        step("R8 load2", 0, 8'h00, 1, 8'h40, 1, 64'h0000_0000_0000_0001, ones);
        // R9: the mask holds when nothing is written
        step("R9 hold", 0, 8'h00, 0, 8'h00, 0, '0, 64'h1357_9BDF_2468_ACE0);
        // Random overlap of all three write paths
        for (int k = 0; k < 3000; k++) begin
            step("R2 R4 R7 R8 R11 rand",
                 ($urandom % 3) == 0, 8'($urandom),
                 ($urandom % 2) == 0, 8'($urandom),
                 ($urandom % 11) == 0, {$urandom, $urandom},
                 {$urandom, $urandom});
        end
        report();
    end
endmodule